// File: doc/BRIEF.md
# Serial Sliding Byte-Pattern Correlator

This block scores how closely the most recent bytes of an incoming stream match a stored reference pattern. The reference bytes and the active pattern length are written beforehand through a plain configuration port. Each accepted stream byte enters a circular history memory. A single shared signed multiplier then walks every tap, one product per clock. Once the walk completes, the block outputs the summed products as a signed integer score together with a one-cycle strobe. The score is graded, not a match flag: the more closely the window tracks the pattern, the larger the score.

Each byte is treated as signed by subtracting 128 before it is multiplied. The design expects input samples to be far apart in time, much longer than one sweep. The stream input uses a valid/ready pair, but this is a drop interface and not back-pressure. `s_ready` is low while a sweep runs and during a configuration write. A byte offered while `s_ready` is low is discarded and reported on `overrun`. A source must therefore not count on holding data until it is taken. The score output has no ready and cannot be stalled.

Top module: `pattern_correlator`

## Requirements
- R1: A write with `cfg_pat_we` high stores `cfg_pat_data` as pattern byte `cfg_pat_addr`. Pattern byte k is the tap weight for the sample k positions older than the newest one.
- R2: A write with `cfg_len_we` high sets the active length L to `cfg_len` when 1 <= `cfg_len` <= MAX_LEN. Any other value is ignored entirely and leaves length, history and scoring unchanged. After reset, L = MAX_LEN.
- R3: Every byte b, pattern or sample, enters the product as the signed value b-128. A pattern byte of 0x80 therefore contributes nothing.
- R4: When the score is output, it equals the sum over k = 0..L-1 of (p[k]-128)*(x[n-k]-128), where x[n] is the newest accepted sample.
- R5: `score_valid` is a one-cycle pulse on the (L+1)-th rising edge after the edge that accepted the newest sample. `s_ready` is high again in the cycle of the pulse, unless a configuration write is in progress.
- R6: While a sweep runs, `s_ready` is low. A byte offered while `s_ready` is low is discarded, never enters the history, and causes `overrun` to pulse high in the following cycle.
- R7: No score is produced until at least L samples have been accepted since reset or since the last configuration write that took effect.
- R8: A pattern write, or a length write that takes effect, empties the history, resets the sample count and cancels any running sweep without producing a score.
- R9: The score is ACC_W = 16 + log2(MAX_LEN) bits signed and never overflows. With L = MAX_LEN, all-0x00 pattern and samples give L*16384.
- R10: After reset, `s_ready` is high and both `score_valid` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pat_we | input | 1 | Pattern byte write strobe |
| cfg_pat_addr | input | AW | Pattern byte index (tap number) |
| cfg_pat_data | input | 8 | Pattern byte value |
| cfg_len_we | input | 1 | Pattern length write strobe |
| cfg_len | input | AW+1 | New pattern length |
| s_valid | input | 1 | Sample byte offered |
| s_data | input | 8 | Sample byte |
| s_ready | output | 1 | Sample would be accepted this cycle |
| overrun | output | 1 | Previous cycle's offered sample was dropped |
| score | output | ACC_W | Signed correlation score |
| score_valid | output | 1 | One-cycle strobe for `score` |

## Verification
The bench builds the block with MAX_LEN = 16. With that setting the 4-bit history index wraps several times during a run, and the largest length, 16, is reached within a few dozen samples. At this size the extreme all-0x00 and all-0xFF windows reach magnitudes close to the 20-bit score range. Running short lengths of 3 and 5 alongside lets the bench check priming, aborts and overruns against exact sweep latencies that can be counted by hand.

// File: rtl/corr_pkg.sv
package corr_pkg;
  // Map an offset-binary byte to two's complement (value - 128).
  function automatic logic signed [7:0] centre(input logic [7:0] b);
    return {~b[7], b[6:0]};
  endfunction
endpackage

// File: rtl/corr_ram.sv
module corr_ram #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/corr_seq.sv
module corr_seq #(
  parameter int MAX_LEN = 512,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_pat_we,
  input  logic          cfg_len_we,
  input  logic [LW-1:0] cfg_len,
  input  logic          s_valid,
  output logic          s_ready,
  output logic          overrun,
  output logic          hist_we,
  output logic [AW-1:0] hist_waddr,
  output logic [AW-1:0] hist_raddr,
  output logic [AW-1:0] pat_raddr,
  output logic          rd_valid,
  output logic          rd_first,
  output logic          rd_last,
  output logic          abort
);
  logic [LW-1:0] len_q, cnt_q, cnt_nx;
  logic [AW-1:0] wp_q, base_q, k_q;
  logic issuing_q, busy_q, rd_valid_q, rd_first_q, rd_last_q, ovr_q;
  logic len_ok, cfg_any, accept, last_tap;

  assign len_ok   = (cfg_len != '0) && (cfg_len <= LW'(MAX_LEN));
  assign cfg_any  = cfg_pat_we | (cfg_len_we & len_ok);
  assign s_ready  = !busy_q && !cfg_any;
  assign accept   = s_valid && s_ready;
  assign cnt_nx   = (cnt_q == len_q) ? len_q : cnt_q + 1'b1;
  assign last_tap = ({1'b0, k_q} == len_q - 1'b1);

  assign hist_we    = accept;
  assign hist_waddr = wp_q;
  assign hist_raddr = base_q - k_q;
  assign pat_raddr  = k_q;
  assign rd_valid   = rd_valid_q;
  assign rd_first   = rd_first_q;
  assign rd_last    = rd_last_q;
  assign abort      = cfg_any;
  assign overrun    = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q      <= LW'(MAX_LEN);
      cnt_q      <= '0;
      wp_q       <= '0;
      base_q     <= '0;
      k_q        <= '0;
      issuing_q  <= 1'b0;
      busy_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_first_q <= 1'b0;
      rd_last_q  <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      ovr_q <= s_valid && !s_ready;
      if (cfg_any) begin
        cnt_q      <= '0;
        wp_q       <= '0;
        issuing_q  <= 1'b0;
        busy_q     <= 1'b0;
        rd_valid_q <= 1'b0;
        rd_first_q <= 1'b0;
        rd_last_q  <= 1'b0;
        if (cfg_len_we && len_ok) len_q <= cfg_len;
      end else begin
        rd_valid_q <= issuing_q;
        rd_first_q <= issuing_q && (k_q == '0);
        rd_last_q  <= issuing_q && last_tap;
        if (issuing_q) begin
          k_q <= k_q + 1'b1;
          if (last_tap) issuing_q <= 1'b0;
        end
        if (rd_valid_q && rd_last_q) busy_q <= 1'b0;
        if (accept) begin
          wp_q  <= wp_q + 1'b1;
          cnt_q <= cnt_nx;
          if (cnt_nx == len_q) begin
            busy_q    <= 1'b1;
            issuing_q <= 1'b1;
            k_q       <= '0;
            base_q    <= wp_q;
          end
        end
      end
    end
  end

  // R7: a sweep only runs once the window is fully primed
  p_sweep_primed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q == len_q));

  // R6: a refused offer is reported one cycle later
  p_overrun_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> overrun);

  // R6: reads in flight keep the input closed
  p_closed_in_sweep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> !s_ready);

  // R2: active length stays inside the legal range
  always_comb begin
    if (rst_n) p_len_range_r2: assert (len_q != '0 && len_q <= LW'(MAX_LEN));
  end
endmodule

// File: rtl/corr_mac.sv
module corr_mac #(
  parameter int MAX_LEN = 512,
  localparam int AW    = $clog2(MAX_LEN),
  localparam int ACC_W = 16 + AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              pat_b,
  input  logic [7:0]              hist_b,
  input  logic                    rd_valid,
  input  logic                    rd_first,
  input  logic                    rd_last,
  input  logic                    abort,
  output logic signed [ACC_W-1:0] score,
  output logic                    score_valid
);
  import corr_pkg::*;

  logic signed [15:0]      prod;
  logic signed [ACC_W-1:0] acc_q, acc_in, prod_x, sum;

  assign prod   = centre(pat_b) * centre(hist_b);
  assign prod_x = {{AW{prod[15]}}, prod};
  assign acc_in = rd_first ? '0 : acc_q;
  assign sum    = acc_in + prod_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      score       <= '0;
      score_valid <= 1'b0;
    end else begin
      score_valid <= 1'b0;
      if (rd_valid && !abort) begin
        acc_q <= sum;
        if (rd_last) begin
          score       <= sum;
          score_valid <= 1'b1;
        end
      end
    end
  end

  // R9: no signed wrap while accumulating
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !abort) |->
      !((acc_in[ACC_W-1] == prod_x[ACC_W-1]) && (sum[ACC_W-1] != acc_in[ACC_W-1])));
endmodule

// File: rtl/pattern_correlator.sv
module pattern_correlator #(
  parameter int MAX_LEN = 512,
  localparam int AW    = $clog2(MAX_LEN),
  localparam int LW    = AW + 1,
  localparam int ACC_W = 16 + AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_pat_we,
  input  logic [AW-1:0]           cfg_pat_addr,
  input  logic [7:0]              cfg_pat_data,
  input  logic                    cfg_len_we,
  input  logic [LW-1:0]           cfg_len,
  input  logic                    s_valid,
  input  logic [7:0]              s_data,
  output logic                    s_ready,
  output logic                    overrun,
  output logic signed [ACC_W-1:0] score,
  output logic                    score_valid
);
  logic          hist_we, rd_valid, rd_first, rd_last, abort;
  logic [AW-1:0] hist_waddr, hist_raddr, pat_raddr;
  logic [7:0]    pat_b, hist_b;

  corr_seq #(.MAX_LEN(MAX_LEN)) seq_i (
    .clk, .rst_n, .cfg_pat_we, .cfg_len_we, .cfg_len, .s_valid,
    .s_ready, .overrun, .hist_we, .hist_waddr, .hist_raddr, .pat_raddr,
    .rd_valid, .rd_first, .rd_last, .abort
  );

  corr_ram #(.DW(8), .AW(AW)) pat_ram_i (
    .clk, .we(cfg_pat_we), .waddr(cfg_pat_addr), .wdata(cfg_pat_data),
    .raddr(pat_raddr), .rdata(pat_b)
  );

  corr_ram #(.DW(8), .AW(AW)) hist_ram_i (
    .clk, .we(hist_we), .waddr(hist_waddr), .wdata(s_data),
    .raddr(hist_raddr), .rdata(hist_b)
  );

  corr_mac #(.MAX_LEN(MAX_LEN)) mac_i (
    .clk, .rst_n, .pat_b, .hist_b, .rd_valid, .rd_first, .rd_last, .abort,
    .score, .score_valid
  );

  // R5: the score strobe lasts a single cycle
  p_score_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    score_valid |=> !score_valid);

  // R5: input reopens together with the score
  p_ready_with_score_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (score_valid && !cfg_pat_we && !cfg_len_we) |-> s_ready);

  // R8: a pattern write cancels any pending score
  p_cfg_cancels_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pat_we |=> !score_valid);
endmodule

// File: tb/pattern_correlator_tb_top.sv
`timescale 1ns/1ps
module pattern_correlator_tb_top;
  localparam int MAX_LEN = 16;
  localparam int AW = $clog2(MAX_LEN);
  localparam int LW = AW + 1;
  localparam int ACC_W = 16 + AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pat_we = 1'b0;
  logic [AW-1:0] cfg_pat_addr = '0;
  logic [7:0] cfg_pat_data = '0;
  logic cfg_len_we = 1'b0;
  logic [LW-1:0] cfg_len = '0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, overrun, score_valid;
  logic signed [ACC_W-1:0] score;

  int n_tests = 0;
  int n_fail = 0;
  int mlen = MAX_LEN;
  int pat [MAX_LEN];
  int hq [$];

  always #5 clk = ~clk;

  pattern_correlator #(.MAX_LEN(MAX_LEN)) dut_i (
    .clk, .rst_n, .cfg_pat_we, .cfg_pat_addr, .cfg_pat_data, .cfg_len_we,
    .cfg_len, .s_valid, .s_data, .s_ready, .overrun, .score, .score_valid
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_score();
    int s = 0;
    for (int k = 0; k < mlen; k++)
      s += (pat[k] - 128) * (hq[hq.size() - 1 - k] - 128);
    return s;
  endfunction

  task automatic wr_pat(input int a, input int d);
    @(negedge clk);
    cfg_pat_we = 1'b1; cfg_pat_addr = AW'(a); cfg_pat_data = 8'(d);
    @(negedge clk);
    cfg_pat_we = 1'b0;
    pat[a] = d;
    hq.delete();
  endtask

  task automatic wr_len(input int l);
    @(negedge clk);
    cfg_len_we = 1'b1; cfg_len = LW'(l);
    @(negedge clk);
    cfg_len_we = 1'b0;
    if (l >= 1 && l <= MAX_LEN) begin
      mlen = l;
      hq.delete();
    end
  endtask

  // Offer one byte, then watch for the score and check value and latency.
  task automatic push(input int d, input string tag);
    bit rdy;
    int hit = 0;
    int got = 0;
    @(negedge clk);
    s_valid = 1'b1; s_data = 8'(d); rdy = s_ready;
    @(negedge clk);
    s_valid = 1'b0;
    check(rdy, "R6 ready while idle", int'(rdy), 1);
    hq.push_back(d);
    for (int i = 1; i <= mlen + 4; i++) begin
      @(negedge clk);
      if (score_valid && hit == 0) begin hit = i; got = int'(score); end
    end
    if (hq.size() >= mlen) begin
      check(hit == mlen + 1, "R5 score latency", hit, mlen + 1);
      check(got == model_score(), tag, got, model_score());
    end else begin
      check(hit == 0, "R7 no score before primed", hit, 0);
    end
  endtask

  task automatic t_reset();
    check(s_ready == 1'b1, "R10 ready after reset", int'(s_ready), 1);
    check(score_valid == 1'b0, "R10 no score after reset", int'(score_valid), 0);
    check(overrun == 1'b0, "R10 no overrun after reset", int'(overrun), 0);
  endtask

  task automatic t_prime();
    int p [5] = '{10, 200, 128, 0, 255};
    wr_len(5);
    for (int k = 0; k < 5; k++) wr_pat(k, p[k]);
    push(8'h12, "R7 partial window");
    push(8'hE0, "R7 partial window");
    push(8'h80, "R7 partial window");
    push(8'h01, "R7 partial window");
    push(8'hA5, "R1 R4 first full score");
  endtask

  task automatic t_stream();
    push(8'h80, "R4 stream zero sample");
    push(8'h00, "R4 stream min sample");
    push(8'hFF, "R4 stream max sample");
    push(8'h37, "R4 stream mid sample");
    push(8'hC4, "R4 stream mixed");
    for (int k = 0; k < 5; k++) wr_pat(k, 8'h80);
    for (int j = 0; j < 5; j++) push(8'h10 + 40 * j, "R3 neutral pattern gives zero");
    check(model_score() == 0, "R3 model zero", model_score(), 0);
  endtask

  task automatic t_overrun();
    int hit = 0;
    int got = 0;
    wr_pat(0, 8'h90); wr_pat(1, 8'h20); wr_pat(2, 8'hF0);
    wr_pat(3, 8'h55); wr_pat(4, 8'h81);
    for (int j = 0; j < 4; j++) push(8'h33 + 17 * j, "R7 refill");
    @(negedge clk);
    s_valid = 1'b1; s_data = 8'h6C;
    @(negedge clk);
    s_data = 8'hEE;
    check(s_ready == 1'b0, "R6 closed during sweep", int'(s_ready), 0);
    @(negedge clk);
    s_valid = 1'b0;
    check(overrun == 1'b1, "R6 overrun pulse", int'(overrun), 1);
    hq.push_back(8'h6C);
    for (int i = 2; i <= mlen + 4; i++) begin
      @(negedge clk);
      if (score_valid && hit == 0) begin hit = i; got = int'(score); end
    end
    check(hit == mlen + 1, "R5 latency with overrun", hit, mlen + 1);
    check(got == model_score(), "R6 score unaffected", got, model_score());
    check(overrun == 1'b0, "R6 overrun single pulse", int'(overrun), 0);
    push(8'h02, "R6 dropped byte absent from history");
  endtask

  task automatic t_len();
    wr_len(0);
    push(8'h44, "R2 zero length ignored");
    wr_len(MAX_LEN + 1);
    push(8'h9A, "R2 oversize length ignored");
    wr_len(MAX_LEN);
    for (int k = 0; k < MAX_LEN; k++) wr_pat(k, 8'h00);
    for (int j = 0; j < MAX_LEN; j++) push(8'h00, "R9 max positive");
    check(model_score() == MAX_LEN * 16384, "R9 model max", model_score(), MAX_LEN * 16384);
    for (int j = 0; j < MAX_LEN; j++) push(8'hFF, "R9 max negative");
    check(model_score() == -MAX_LEN * 16256, "R9 model min", model_score(), -MAX_LEN * 16256);
  endtask

  task automatic t_abort();
    int hit = 0;
    wr_len(3);
    wr_pat(0, 8'h70); wr_pat(1, 8'hB0); wr_pat(2, 8'h05);
    push(8'h11, "R8 refill"); push(8'h99, "R8 refill"); push(8'hF3, "R8 full score");
    @(negedge clk);
    s_valid = 1'b1; s_data = 8'h3D;
    @(negedge clk);
    s_valid = 1'b0;
    cfg_pat_we = 1'b1; cfg_pat_addr = '0; cfg_pat_data = 8'h99;
    @(negedge clk);
    cfg_pat_we = 1'b0;
    pat[0] = 8'h99;
    hq.delete();
    for (int i = 0; i < mlen + 4; i++) begin
      @(negedge clk);
      if (score_valid) hit++;
    end
    check(hit == 0, "R8 sweep cancelled", hit, 0);
    push(8'h21, "R8 history emptied");
    push(8'hD2, "R8 history emptied");
    push(8'h7F, "R8 score from new samples only");
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prime();
    t_stream();
    t_overrun();
    t_len();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule